// File: doc/BRIEF.md
# Memory Barrier Completion Sequencer

This block runs a single memory-barrier instruction for one processor's memory subsystem. When the issue stage hands it a barrier, it stalls instruction execution and steps through a fixed sequence. First it waits for the integer issue queue to empty. Then it asks the system port to send out the pending miss and I/O write entries. It then watches the outstanding committed-event count until that count reaches zero, and at that moment it tags the youngest probe-queue entry. Finally it waits for two things: the local request queues must drain, and a probe response must be sent for the tagged entry. Only then does it lift the stall.

The barrier is not complete when the local queues are empty. It is complete only once an event visible to other processors has been observed: the probe response for the tagged entry. A configuration input can select an alternate mode in which the barrier is handled on the system bus. In that mode the sequencer only hands the barrier to the external path and waits for that path to acknowledge it.

Top module: `mbar_seq`

## Requirements
- R1: `stall` goes high in the cycle after a request is accepted in idle. It stays high until the cycle after `bar_done`, and it is low after reset.
- R2: In normal mode (`bus_mode_en`=0), `flush_req` rises only after `iq_empty` has been seen high. Once raised, it stays high until the cycle in which `flush_ack` is high.
- R3: After the flush is acknowledged, the youngest entry is tagged only in a cycle where `ev_cnt` is zero. While the count is nonzero, the sequencer keeps waiting.
- R4: Tagging is a one-cycle `pq_mark` pulse. If `pq_empty` is high in the tagging cycle, no pulse is given and the response condition counts as already met.
- R5: Completion requires `maf_dref`=0 and `sq_empty`, `lq_empty` and `iowb_empty` all high in the completing cycle.
- R6: Completion requires a `pq_resp` pulse seen in the tagging cycle's successor or later. A response seen before the tag has no effect.
- R7: In bus mode (`bus_mode_en`=1 at acceptance), `bus_bar_go` pulses for exactly one cycle, in the cycle after acceptance. No flush or tag is issued, and the stall is held until `bus_bar_ack`.
- R8: A request presented while `stall` is high is ignored and does not start a new sequence after the current one ends.
- R9: `bar_done` pulses for one cycle when the sequence completes. In normal mode, that cycle is the first one in which both the drain and response conditions hold. In bus mode, it is the cycle in which the acknowledge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bar_req | input | 1 | Barrier request from the issue stage |
| bus_mode_en | input | 1 | Selects the bus-level barrier mode |
| iq_empty | input | 1 | Integer issue queue is empty |
| flush_ack | input | 1 | System port accepted the pending-entry flush |
| ev_cnt | input | CNT_W | Outstanding committed-event count |
| maf_dref | input | 1 | Miss address file holds data-stream references |
| sq_empty | input | 1 | Store queue empty |
| lq_empty | input | 1 | Load queue empty |
| iowb_empty | input | 1 | I/O write buffer empty |
| pq_empty | input | 1 | Probe queue has no entries |
| pq_resp | input | 1 | Probe response sent for the tagged entry |
| bus_bar_ack | input | 1 | External bus barrier path finished |
| stall | output | 1 | Holds instruction execution |
| flush_req | output | 1 | Request to send pending entries to the system port |
| pq_mark | output | 1 | Tag the youngest probe-queue entry |
| bus_bar_go | output | 1 | Hand-off pulse to the bus barrier path |
| bar_done | output | 1 | Barrier sequence completes this cycle |

## Verification
The bench checks three ways a design could release the barrier too early.
- It gives a probe response before the tag, then drains the queues. A design that counts that early response would lift the stall without a valid response.
- It holds the event count at one with the probe queue occupied. A design that tags on flush acknowledge rather than on the count reaching zero would pulse `pq_mark` too soon.
- It keeps the store queue busy after the response. A design that does not wait for the drain would finish while entries are still outstanding.

The bench also covers several other cases. With the probe queue empty at the tag, it expects completion without any response. In bus mode, it expects a single hand-off pulse. When a request arrives during a barrier, it expects that request to be dropped rather than queued behind the current one.

// File: rtl/mbar_seq.sv
module mbar_seq #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bar_req,
  input  logic             bus_mode_en,
  input  logic             iq_empty,
  input  logic             flush_ack,
  input  logic [CNT_W-1:0] ev_cnt,
  input  logic             maf_dref,
  input  logic             sq_empty,
  input  logic             lq_empty,
  input  logic             iowb_empty,
  input  logic             pq_empty,
  input  logic             pq_resp,
  input  logic             bus_bar_ack,
  output logic             stall,
  output logic             flush_req,
  output logic             pq_mark,
  output logic             bus_bar_go,
  output logic             bar_done
);

  typedef enum logic [2:0] {
    S_IDLE, S_IQ, S_FLUSH, S_TAG, S_DRAIN, S_BGO, S_BWAIT
  } st_t;

  st_t  st, st_nx;
  logic resp_got;
  logic tag_now, drained, resp_ok;

  assign tag_now    = (st == S_TAG) && (ev_cnt == '0);
  assign drained    = !maf_dref && sq_empty && lq_empty && iowb_empty;
  assign resp_ok    = resp_got || pq_resp;

  assign stall      = (st != S_IDLE);
  assign flush_req  = (st == S_FLUSH);
  assign pq_mark    = tag_now && !pq_empty;
  assign bus_bar_go = (st == S_BGO);
  assign bar_done   = ((st == S_DRAIN) && drained && resp_ok) ||
                      ((st == S_BWAIT) && bus_bar_ack);

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:  if (bar_req) st_nx = bus_mode_en ? S_BGO : S_IQ;
      S_IQ:    if (iq_empty) st_nx = S_FLUSH;
      S_FLUSH: if (flush_ack) st_nx = S_TAG;
      S_TAG:   if (tag_now) st_nx = S_DRAIN;
      S_DRAIN: if (bar_done) st_nx = S_IDLE;
      S_BGO:   st_nx = S_BWAIT;
      S_BWAIT: if (bus_bar_ack) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      resp_got <= 1'b0;
    end else begin
      st <= st_nx;
      if (tag_now)
        resp_got <= pq_empty;
      else if (st == S_DRAIN && pq_resp)
        resp_got <= 1'b1;
      else if (st == S_IDLE)
        resp_got <= 1'b0;
    end
  end

endmodule

// File: rtl/mbar_seq_chk.sv
module mbar_seq_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iq_empty,
  input logic             flush_ack,
  input logic [CNT_W-1:0] ev_cnt,
  input logic             maf_dref,
  input logic             sq_empty,
  input logic             lq_empty,
  input logic             iowb_empty,
  input logic             pq_empty,
  input logic             bus_bar_ack,
  input logic             stall,
  input logic             flush_req,
  input logic             pq_mark,
  input logic             bus_bar_go,
  input logic             bar_done
);

  assert_busy_stalls_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req || pq_mark || bus_bar_go) |-> stall);

  assert_flush_after_iq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_req) |-> $past(iq_empty));

  assert_flush_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_ack) |=> flush_req);

  assert_tag_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pq_mark |-> (ev_cnt == '0 && !pq_empty));

  assert_tag_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pq_mark |=> !pq_mark);

  assert_done_drained_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_done && !bus_bar_ack) |-> (!maf_dref && sq_empty && lq_empty && iowb_empty));

  assert_go_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_bar_go |=> !bus_bar_go);

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bar_done |=> !stall);

endmodule

bind mbar_seq mbar_seq_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .iq_empty(iq_empty), .flush_ack(flush_ack),
  .ev_cnt(ev_cnt), .maf_dref(maf_dref), .sq_empty(sq_empty),
  .lq_empty(lq_empty), .iowb_empty(iowb_empty), .pq_empty(pq_empty),
  .bus_bar_ack(bus_bar_ack), .stall(stall), .flush_req(flush_req),
  .pq_mark(pq_mark), .bus_bar_go(bus_bar_go), .bar_done(bar_done)
);

// File: tb/mbar_seq_tb_top.sv
module mbar_seq_tb_top;
  localparam int CNT_W = 4;
  localparam int EV_MARK = 1, EV_DONE = 2, EV_GO = 3;

  logic clk = 0, rst_n = 0;
  logic bar_req = 0, bus_mode_en = 0, iq_empty = 1, flush_ack = 0;
  logic [CNT_W-1:0] ev_cnt = '0;
  logic maf_dref = 0, sq_empty = 1, lq_empty = 1, iowb_empty = 1;
  logic pq_empty = 0, pq_resp = 0, bus_bar_ack = 0;
  logic stall, flush_req, pq_mark, bus_bar_go, bar_done;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];

  always #4 clk = ~clk;

  mbar_seq #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bar_req(bar_req), .bus_mode_en(bus_mode_en),
    .iq_empty(iq_empty), .flush_ack(flush_ack), .ev_cnt(ev_cnt),
    .maf_dref(maf_dref), .sq_empty(sq_empty), .lq_empty(lq_empty),
    .iowb_empty(iowb_empty), .pq_empty(pq_empty), .pq_resp(pq_resp),
    .bus_bar_ack(bus_bar_ack), .stall(stall), .flush_req(flush_req),
    .pq_mark(pq_mark), .bus_bar_go(bus_bar_go), .bar_done(bar_done)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pop_ev(int code);
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL R3/R7/R9 event: actual %0d expected none", code);
    end else begin
      int e = exp_q.pop_front();
      if (e != code) begin
        n_fail++;
        $display("FAIL R3/R7/R9 event order: actual %0d expected %0d", code, e);
      end
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (pq_mark)    pop_ev(EV_MARK);
    if (bus_bar_go) pop_ev(EV_GO);
    if (bar_done)   pop_ev(EV_DONE);
  end

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step();
    chk("R1 reset stall", stall, 0);
    chk("R1 reset flush", flush_req, 0);

    // Scenario A: iq busy, count 2->1->0, early resp, store queue busy
    iq_empty = 0; ev_cnt = 2; sq_empty = 0; pq_empty = 0;
    bar_req = 1; step(); bar_req = 0; #1;
    chk("R1 stall after accept", stall, 1);
    chk("R2 no flush while iq busy", flush_req, 0);
    step(2);
    chk("R2 still no flush", flush_req, 0);
    iq_empty = 1; step(); #1;
    chk("R2 flush raised", flush_req, 1);
    step(); #1;
    chk("R2 flush held without ack", flush_req, 1);
    flush_ack = 1; step(); flush_ack = 0; ev_cnt = 1; pq_resp = 1; #1;
    chk("R3 no tag at count 1", pq_mark, 0);
    step(); pq_resp = 0; ev_cnt = 0; exp_q.push_back(EV_MARK); #1;
    chk("R3 tag at count 0", pq_mark, 1);
    step(); pq_resp = 1; #1;
    chk("R5 no done while store queue busy", bar_done, 0);
    step(); pq_resp = 0; bar_req = 1; #1;
    chk("R8 stall held, request ignored", stall, 1);
    step(); bar_req = 0; step();
    sq_empty = 1; exp_q.push_back(EV_DONE); #1;
    chk("R9 done when drained and responded", bar_done, 1);
    step(); #1;
    chk("R1 stall released", stall, 0);
    step(2);
    chk("R8 no second sequence", stall, 0);

    // Scenario B: response before tag ignored
    ev_cnt = 0; pq_empty = 0;
    bar_req = 1; step(); bar_req = 0;
    step(); pq_resp = 1; #1;
    chk("R2 flush raised B", flush_req, 1);
    flush_ack = 1; step(); flush_ack = 0; pq_resp = 0;
    exp_q.push_back(EV_MARK); #1;
    chk("R3 immediate tag at zero", pq_mark, 1);
    step(3);
    chk("R6 early response ignored", stall, 1);
    chk("R6 no done without response", bar_done, 0);
    pq_resp = 1; exp_q.push_back(EV_DONE); #1;
    chk("R6 done on response", bar_done, 1);
    step(); pq_resp = 0; #1;
    chk("R1 stall released B", stall, 0);

    // Scenario C: probe queue empty at tag
    pq_empty = 1; flush_ack = 1;
    bar_req = 1; step(); bar_req = 0;
    step(); step(); flush_ack = 0; #1;
    chk("R4 no pulse with empty probe queue", pq_mark, 0);
    step(); exp_q.push_back(EV_DONE); #1;
    chk("R4 done without response", bar_done, 1);
    step(); #1;
    chk("R1 stall released C", stall, 0);

    // Scenario D: bus mode
    bus_mode_en = 1; pq_empty = 0;
    bar_req = 1; step(); bar_req = 0; exp_q.push_back(EV_GO); #1;
    chk("R7 go pulse", bus_bar_go, 1);
    chk("R7 stall in bus mode", stall, 1);
    chk("R7 no flush in bus mode", flush_req, 0);
    step(); #1;
    chk("R7 go single cycle", bus_bar_go, 0);
    step(2);
    chk("R7 stall until ack", stall, 1);
    bus_bar_ack = 1; exp_q.push_back(EV_DONE); #1;
    chk("R9 done on ack", bar_done, 1);
    step(); bus_bar_ack = 0; bus_mode_en = 0; #1;
    chk("R7 stall released on ack", stall, 0);

    step(2);
    chk("R9 all expected events seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule